// File: doc/BRIEF.md
# Serial Memory Device Controller

This block is the device end of a serial nonvolatile byte memory reached over a four-wire SPI bus in mode 0. The bus master frames each command with an active-low select. The first byte of the frame is an opcode. Some opcodes stand alone. Others are followed by one status byte, in or out. Memory commands are followed by a three-byte address and then a stream of data bytes. The block keeps a byte array of parameterized depth, a small status register and a write-enable latch. The latch must be set by its own command before each status write or memory write, and it clears itself once that write is done.

All bus inputs are registered into the block clock `clk`, which must run at least eight times faster than the serial clock. Edges of the serial clock are found inside the block. After reset the block counts idle cycles (select high) and ignores any select that begins before `LOCK_CYC` such cycles have passed.

The control machine has these states:
- `ST_LOCKED`: the reset state. It goes to `ST_IDLE` once the idle count is reached while select is high.
- `ST_IDLE`: waits for the opcode byte. From here it goes to `ST_SKIP`, `ST_SROUT`, `ST_SRIN` or `ST_ADDR`.
- `ST_ADDR`: collects three address bytes, then goes to `ST_RDATA` (read), `ST_DUMMY` (fast read) or `ST_WDATA` (write).
- `ST_DUMMY`: takes one byte and goes to `ST_RDATA`.
- `ST_RDATA` and `ST_WDATA`: stream bytes until the select is raised.
- `ST_SROUT` and `ST_SRIN`: move one status byte, then go to `ST_SKIP`.
- `ST_SKIP`: discards every further bit of the frame.

Raising the select sends every state except `ST_LOCKED` back to `ST_IDLE`.

Top module: `sermem_dev`

## Requirements
- R1: After reset the write-enable latch is 0 and the status reads 0x00. A select that begins before `LOCK_CYC` idle cycles have passed is ignored for its whole length: no output, and no effect on the latch.
- R2: Every transfer is a whole byte sent most significant bit first. `mosi` is sampled on rising `sck`. `miso` changes only after falling `sck`.
- R3: Opcode 0x06 sets the latch and opcode 0x04 clears it. The latch is seen as bit 1 of the status byte.
- R4: Opcode 0x05 returns exactly one byte, laid out as {bit7, 0, 0, 0, bit3, bit2, latch, 0}. The output is not driven for any later byte of the same frame.
- R5: Opcode 0x01 followed by one byte stores only bits 7, 3 and 2 of that byte. Bits 1 and 0 of the data have no effect.
- R6: Opcode 0x02 takes a three-byte address, most significant byte first, and ignores the bits above the array index. Each following data byte is written to the next address, wrapping from the last entry to 0.
- R7: Opcode 0x03 takes a three-byte address and returns array bytes from that address, incrementing per byte and wrapping at the end.
- R8: Opcode 0x0B takes a three-byte address and one dummy byte, then returns data as R7 does. No output is driven during the dummy byte.
- R9: A 0x01 or 0x02 command that starts while the latch is 0 is discarded. The status and the array are left unchanged.
- R10: When the select rises after at least one status or memory byte was written in that frame, the latch clears. A write frame that ends before its first data byte leaves the latch set.
- R11: Raising the select aborts any command at any bit. `miso_oe` is 1 only while a status byte or read data is being shifted out.
- R12: Opcodes 0xB9, 0x9F, 0xC3 and all undefined codes are ignored. They produce no output and change neither the latch, the status nor the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Serial clock, idles low (mode 0) |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when not enabled |
| miso_oe | output | 1 | Drive enable for `miso` (low means high impedance) |

## Verification
The assertions check these rules on every cycle:
- the output enable is never high while the select is high or while the block is locked;
- the latch rises only after a 0x06 opcode and falls only after a 0x04 opcode or the end of a write frame;
- no array or status write happens while the latch is clear;
- the driven output bit changes only after a falling serial clock.

Other behaviour can only be shown by the bench's scenarios:
- the data values;
- address wrap;
- the dummy byte of a fast read;
- the mask on status writes;
- the exact single-byte length of a status read;
- the discarding of ignored and aborted commands.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    typedef enum logic [3:0] {
        ST_LOCKED,
        ST_IDLE,
        ST_ADDR,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_SROUT,
        ST_SRIN,
        ST_SKIP
    } st_e;

    typedef enum logic [1:0] {
        CM_READ,
        CM_FAST,
        CM_WRITE
    } cmd_e;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // status bits that a status write may change
    localparam logic [7:0] SR_WMASK = 8'h8C;
    localparam int         WEL_BIT  = 1;
    localparam int         ADDR_BYTES = 3;

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_q,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_q
);
    logic sck_q, sck_p, cs_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            cs_p   <= 1'b1;
            sck_q  <= 1'b0;
            sck_p  <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            cs_p   <= cs_q;
            sck_q  <= sck;
            sck_p  <= sck_q;
            mosi_q <= mosi;
        end
    end

    assign cs_rise  = cs_q & ~cs_p;
    assign sck_rise = sck_q & ~sck_p & ~cs_q;
    assign sck_fall = ~sck_q & sck_p & ~cs_q;
endmodule

// File: rtl/sermem_shift.sv
module sermem_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_q,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       mosi_q,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       rx_done,
    output logic [7:0] rx_byte,
    output logic       tx_bit
);
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (cs_q) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_q};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    assign rx_done = sck_rise & (bit_cnt == 3'd7);
    assign rx_byte = {rx_sh, mosi_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            tx_bit <= 1'b0;
        end else if (tx_load) begin
            tx_sh  <= tx_byte;
        end else if (sck_fall) begin
            tx_bit <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
        end
    end
endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
    import sermem_pkg::*;
#(
    parameter int AW       = 8,
    parameter int LOCK_CYC = 40,
    localparam int CW = $clog2(LOCK_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_q,
    input  logic          cs_rise,
    input  logic          rx_done,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    mem_rdata,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic          sr_we,
    output logic          drive,
    output logic          wel,
    output st_e           state
);
    localparam logic [CW-1:0] LOCK_END = CW'(LOCK_CYC);

    st_e           state_n;
    cmd_e          cmd, cmd_n;
    logic          cmd_ld, wel_set, wel_clr, ptr_set, ptr_inc;
    logic [1:0]    acnt;
    logic [AW-1:0] addr_sh, addr_n, ptr;
    logic [7:0]    sr_keep, status;
    logic          wr_done;
    logic [CW-1:0] lock_cnt;

    assign addr_n = AW'({addr_sh, rx_byte});

    always_comb begin
        status          = sr_keep;
        status[WEL_BIT] = wel;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_n;
    end

    // next state and strobes
    always_comb begin
        state_n   = state;
        tx_load   = 1'b0;
        tx_byte   = mem_rdata;
        mem_we    = 1'b0;
        mem_raddr = ptr;
        sr_we     = 1'b0;
        wel_set   = 1'b0;
        wel_clr   = 1'b0;
        cmd_ld    = 1'b0;
        cmd_n     = CM_READ;
        ptr_set   = 1'b0;
        ptr_inc   = 1'b0;
        unique case (state)
            ST_LOCKED: if (cs_q && lock_cnt == LOCK_END) state_n = ST_IDLE;
            ST_IDLE: if (rx_done) begin
                state_n = ST_SKIP;
                case (rx_byte)
                    OP_WEN:  wel_set = 1'b1;
                    OP_WDIS: wel_clr = 1'b1;
                    OP_RDST: begin
                        state_n = ST_SROUT;
                        tx_load = 1'b1;
                        tx_byte = status;
                    end
                    OP_WRST: if (wel) state_n = ST_SRIN;
                    OP_READ: begin
                        state_n = ST_ADDR; cmd_ld = 1'b1; cmd_n = CM_READ;
                    end
                    OP_FREAD: begin
                        state_n = ST_ADDR; cmd_ld = 1'b1; cmd_n = CM_FAST;
                    end
                    OP_WRITE: if (wel) begin
                        state_n = ST_ADDR; cmd_ld = 1'b1; cmd_n = CM_WRITE;
                    end
                    default: state_n = ST_SKIP;
                endcase
            end
            ST_ADDR: if (rx_done && acnt == 2'(ADDR_BYTES - 1)) begin
                ptr_set   = 1'b1;
                mem_raddr = addr_n;
                unique case (cmd)
                    CM_READ: begin
                        state_n = ST_RDATA;
                        tx_load = 1'b1;
                    end
                    CM_FAST:  state_n = ST_DUMMY;
                    CM_WRITE: state_n = ST_WDATA;
                    default:  state_n = ST_SKIP;
                endcase
            end
            ST_DUMMY, ST_RDATA: if (rx_done) begin
                state_n = ST_RDATA;
                tx_load = 1'b1;
                ptr_inc = 1'b1;
            end
            ST_WDATA: if (rx_done) begin
                mem_we  = 1'b1;
                ptr_inc = 1'b1;
            end
            ST_SROUT: if (rx_done) state_n = ST_SKIP;
            ST_SRIN: if (rx_done) begin
                sr_we   = 1'b1;
                state_n = ST_SKIP;
            end
            ST_SKIP: state_n = ST_SKIP;
            default: state_n = ST_IDLE;
        endcase
        if (state != ST_LOCKED && cs_q) state_n = ST_IDLE;
    end

    // outputs
    always_comb begin
        drive     = ~cs_q & (state == ST_SROUT || state == ST_RDATA);
        mem_waddr = ptr;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd      <= CM_READ;
            acnt     <= '0;
            addr_sh  <= '0;
            ptr      <= '0;
            wel      <= 1'b0;
            sr_keep  <= '0;
            wr_done  <= 1'b0;
            lock_cnt <= '0;
        end else begin
            if (state == ST_LOCKED && cs_q && lock_cnt != LOCK_END)
                lock_cnt <= lock_cnt + CW'(1);
            if (cmd_ld) cmd <= cmd_n;
            if (cs_q) begin
                acnt    <= '0;
                wr_done <= 1'b0;
            end else if (state == ST_ADDR && rx_done) begin
                acnt    <= acnt + 2'd1;
                addr_sh <= addr_n;
            end
            if (ptr_set)
                ptr <= addr_n + ((cmd == CM_READ) ? AW'(1) : AW'(0));
            else if (ptr_inc)
                ptr <= ptr + AW'(1);
            if (sr_we) sr_keep <= rx_byte & SR_WMASK;
            if (sr_we || mem_we) wr_done <= 1'b1;
            if (wel_set) wel <= 1'b1;
            else if (wel_clr || (cs_rise && wr_done)) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/sermem_dev.sv
module sermem_dev
    import sermem_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int LOCK_CYC = 40,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    logic          cs_q, cs_rise, sck_rise, sck_fall, mosi_q;
    logic          rx_done, tx_load, tx_bit, mem_we, sr_we, drive, wel;
    logic [7:0]    rx_byte, tx_byte, mem_rdata;
    logic [AW-1:0] mem_waddr, mem_raddr;
    st_e           state;

    sermem_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_q(cs_q), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_q(mosi_q)
    );

    sermem_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .mosi_q(mosi_q), .tx_load(tx_load),
        .tx_byte(tx_byte), .rx_done(rx_done), .rx_byte(rx_byte),
        .tx_bit(tx_bit)
    );

    sermem_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(rx_byte),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    sermem_ctrl #(.AW(AW), .LOCK_CYC(LOCK_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_rise(cs_rise),
        .rx_done(rx_done), .rx_byte(rx_byte), .mem_rdata(mem_rdata),
        .tx_load(tx_load), .tx_byte(tx_byte), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_raddr(mem_raddr), .sr_we(sr_we),
        .drive(drive), .wel(wel), .state(state)
    );

    assign miso_oe = drive;
    assign miso    = drive & tx_bit;
endmodule

// File: rtl/sermem_chk.sv
module sermem_chk
    import sermem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_q,
    input logic       cs_rise,
    input logic       sck_fall,
    input logic       rx_done,
    input logic [7:0] rx_byte,
    input st_e        state,
    input logic       wel,
    input logic       mem_we,
    input logic       sr_we,
    input logic       miso,
    input logic       miso_oe
);
    assert_hiz_deselect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> !miso_oe);

    assert_locked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> (!wel && !miso_oe && !mem_we && !sr_we));

    assert_latch_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(rx_done && rx_byte == OP_WEN && state == ST_IDLE));

    assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> $past(cs_rise || (rx_done && rx_byte == OP_WDIS && state == ST_IDLE)));

    assert_mem_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    assert_status_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> wel);

    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(sck_fall));
endmodule

bind sermem_dev sermem_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .rx_done(rx_done), .rx_byte(rx_byte),
    .state(state), .wel(wel), .mem_we(mem_we), .sr_we(sr_we),
    .miso(miso), .miso_oe(miso_oe)
);

// File: tb/sermem_dev_test.sv
module sermem_dev_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int nvec = 0;
    int nbad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_sh = '0;
    int         mon_n = 0;

    always #4 clk = ~clk;

    sermem_dev #(.DEPTH(256), .LOCK_CYC(40)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected byte per driven output byte
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            mon_n = 0;
        end else if (miso_oe) begin
            mon_sh = {mon_sh[6:0], miso};
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                nvec++;
                if (exp_q.size() == 0) begin
                    nbad++;
                    $display("FAIL R12: got unexpected byte %h expected none", mon_sh);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (mon_sh !== e) begin
                        nbad++;
                        $display("FAIL %s: got %h expected %h", t, mon_sh, e);
                    end
                end
            end
        end
    end

    task automatic push_exp(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic sb(input logic [7:0] b);
        bits(b, 8);
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic addr(input logic [23:0] a);
        sb(a[23:16]); sb(a[15:8]); sb(a[7:0]);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel(); sb(op); desel();
    endtask

    task automatic rdsr(input logic [7:0] exp, input string tag);
        sel(); sb(8'h05); push_exp(exp, tag); sb(8'h00); desel();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miso_oe === 1'b0, "R11 reset enable", {7'd0, miso_oe}, 8'h00);

        // R1: select during lockout is ignored
        repeat (3) @(negedge clk);
        sel(); sb(8'h06); sb(8'h05); sb(8'h00);
        chk(miso_oe === 1'b0, "R1 lockout output", {7'd0, miso_oe}, 8'h00);
        desel();
        repeat (50) @(negedge clk);
        rdsr(8'h00, "R1 status after reset");

        // R3 latch set and clear
        cmd1(8'h06);
        rdsr(8'h02, "R3 latch set");
        cmd1(8'h04);
        rdsr(8'h00, "R3 latch cleared");

        // R6 write with upper address bits set, R10 latch clears
        cmd1(8'h06);
        sel(); sb(8'h02); addr(24'h0A_01_10); sb(8'h11); sb(8'h22); sb(8'h33); desel();
        rdsr(8'h00, "R10 latch after write");

        // R7 read, R2 bit order
        sel(); sb(8'h03); addr(24'hAB_CD_10);
        repeat (2) @(negedge clk);
        chk(miso_oe === 1'b1, "R11 enable on read", {7'd0, miso_oe}, 8'h01);
        push_exp(8'h11, "R7 read byte 0"); push_exp(8'h22, "R2 read byte 1");
        push_exp(8'h33, "R7 read byte 2");
        sb(8'h00); sb(8'h00); sb(8'h00); desel();

        // R9 write without latch discarded
        sel(); sb(8'h02); addr(24'h00_00_10); sb(8'hAA); desel();
        sel(); sb(8'h03); addr(24'h00_00_10); push_exp(8'h11, "R9 memory kept");
        sb(8'h00); desel();

        // R6/R7 wrap at end of array
        cmd1(8'h06);
        sel(); sb(8'h02); addr(24'h00_00_FE); sb(8'h5A); sb(8'hA5); sb(8'h3C); desel();
        sel(); sb(8'h03); addr(24'h00_00_FE);
        push_exp(8'h5A, "R7 wrap 0xFE"); push_exp(8'hA5, "R7 wrap 0xFF");
        push_exp(8'h3C, "R6 wrap to 0x00");
        sb(8'h00); sb(8'h00); sb(8'h00); desel();

        // R8 fast read with dummy byte
        sel(); sb(8'h0B); addr(24'h00_00_11); sb(8'hFF);
        push_exp(8'h22, "R8 fast byte 0"); push_exp(8'h33, "R8 fast byte 1");
        sb(8'h00); sb(8'h00); desel();

        // R5 status write mask
        cmd1(8'h06);
        sel(); sb(8'h01); sb(8'hFF); desel();
        rdsr(8'h8C, "R5 status mask");
        sel(); sb(8'h01); sb(8'h00); desel();
        rdsr(8'h8C, "R9 status kept");
        cmd1(8'h06);
        sel(); sb(8'h01); sb(8'h04); desel();
        rdsr(8'h04, "R5 status rewrite");

        // R10 write frame without data keeps latch
        cmd1(8'h06);
        sel(); sb(8'h02); addr(24'h00_00_40); desel();
        rdsr(8'h06, "R10 latch kept");
        cmd1(8'h04);

        // R11 abort mid-read and mid-opcode
        sel(); sb(8'h03); addr(24'h00_00_10);
        push_exp(8'h11, "R11 byte before abort");
        sb(8'h00); bits(8'h00, 4);
        @(negedge clk); cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(miso_oe === 1'b0, "R11 abort enable", {7'd0, miso_oe}, 8'h00);
        repeat (6) @(negedge clk);
        sel(); bits(8'h06, 4); @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
        rdsr(8'h04, "R11 partial opcode ignored");

        // R4 exactly one status byte
        sel(); sb(8'h05); push_exp(8'h04, "R4 status byte"); sb(8'h00);
        repeat (3) @(negedge clk);
        chk(miso_oe === 1'b0, "R4 no second byte", {7'd0, miso_oe}, 8'h00);
        sb(8'h00); desel();

        // R12 ignored opcodes
        cmd1(8'h06);
        sel(); sb(8'hB9); sb(8'h02); sb(8'h00); sb(8'h10); desel();
        sel(); sb(8'h9F); sb(8'h00); sb(8'h00); desel();
        sel(); sb(8'hC3); sb(8'h00); sb(8'h00); desel();
        sel(); sb(8'h7E); sb(8'h00); desel();
        rdsr(8'h06, "R12 status unchanged");
        sel(); sb(8'h03); addr(24'h00_00_10); push_exp(8'h11, "R12 memory unchanged");
        sb(8'h00); desel();

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7 pending bytes", 8'(exp_q.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule